// File: doc/BRIEF.md
# SECDED Read Checker with Check-Value Injection

This block sits on the read path of a code memory that holds 64-bit words. Each word is stored with an 8-bit check value. Read requests are passed through to the memory unchanged. When the memory returns a word, its address and its stored check value, the block recomputes the check value from the data and forms a syndrome. It then returns the word to the requester one clock later. A single flipped bit is repaired in the returned data and raises a correctable-fault pulse. A pattern that cannot be repaired gives a bus-error response and an uncorrectable-fault pulse, and the data is passed through as received.

For self-test, software can program one target word address and an 8-bit check value, then set a separate enable bit. While the enable bit is set, a read of the target address uses the programmed value instead of the stored one. This lets software drive the fault paths on purpose. Writing the correct value must give a clean read. Flipping one bit of it must give a corrected read. Flipping two bits must give a bus error. Reads of every other address keep using the stored check value.

Top module: `secded_read_guard`

## Requirements
- R1: After reset the response, bus-error and both fault outputs are low, the injection enable is off, and the target address and injected value are zero.
- R2: The code places the word in positions 1..71. Check bit k (k = 0..6) sits at position 2^k. Data bits 0..63 fill the remaining positions in ascending order. Check bit 7 is even parity over the other 71 bits. A read with a matching check value returns the data unchanged one clock after the memory response is valid, with no fault and no bus error.
- R3: A read with one flipped data bit returns the corrected word, raises the correctable fault and no bus error.
- R4: A read with one flipped check bit, including bit 7, returns the data unchanged and raises the correctable fault.
- R5: A read with two flipped bits returns the data as received, asserts the bus-error response and raises the uncorrectable fault, not the correctable one.
- R6: A register write with select 0 loads the injected check value from data bits [7:0] and the target word address from bits [ADDR_W+7:8]. A write with select 1 loads the enable from bit 0.
- R7: With injection enabled and the correct value programmed, a read of the target returns correct data with no fault, even when the stored check value is wrong.
- R8: With injection enabled, an injected value one bit away from correct gives a corrected read plus a correctable fault. An injected value two bits away gives a bus error plus an uncorrectable fault.
- R9: While injection is enabled, reads of any other address use the stored check value.
- R10: Injection stays in effect over repeated reads until software clears the enable bit. After that, the target uses its stored value.
- R11: A read response arriving in the same cycle as a register write is judged with the settings held before that write.
- R12: Each fault output is a single-cycle pulse. The fault address output carries the address of the faulting read while the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Read request from requester |
| reqAddr | input | ADDR_W | Word address of the read request |
| memReqValid | output | 1 | Read request forwarded to memory |
| memReqAddr | output | ADDR_W | Forwarded word address |
| memRspValid | input | 1 | Memory returns a word this cycle |
| memRspAddr | input | ADDR_W | Word address of the returned data |
| memRspData | input | 64 | Stored data word |
| memRspChk | input | 8 | Stored check value |
| regWrEn | input | 1 | Control register write strobe |
| regWrSel | input | 1 | 0: target/value register, 1: enable register |
| regWrData | input | ADDR_W+8 | Write data |
| rspValid | output | 1 | Response to requester valid |
| rspData | output | 64 | Returned (possibly corrected) data |
| rspErr | output | 1 | Bus-error response |
| corrFault | output | 1 | Correctable-fault pulse |
| uncorrFault | output | 1 | Uncorrectable-fault pulse |
| faultAddr | output | ADDR_W | Address of the faulting read |

## Verification
A register write and a memory response can arrive in the same clock. The bench provokes this by arming a two-bit-wrong injected value on the target. It then drives the write that clears the enable together with a read of the target whose stored check value is correct. The response in that cycle must still carry the bus error and the uncorrectable fault from the old settings. The next read of the target must come back clean.

// File: rtl/eccg_pkg.sv
package eccg_pkg;
  localparam int DATA_W   = 64;
  localparam int HAM_W    = 7;
  localparam int CHK_W    = HAM_W + 1;
  localparam int CODE_LEN = DATA_W + HAM_W;

  typedef struct packed {
    logic             sample;
    logic             useInj;
    logic [CHK_W-1:0] injChk;
  } eccgStrobe_t;

  // codeword position (1..CODE_LEN) of data bit idx; check bits take powers of two
  function automatic int dataPos(input int idx);
    int cnt;
    cnt = 0;
    for (int p = 1; p <= CODE_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  function automatic logic [CHK_W-1:0] calcChk(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int i = 0; i < DATA_W; i++) begin
      int p;
      p = dataPos(i);
      for (int k = 0; k < HAM_W; k++)
        if (p[k]) h[k] = h[k] ^ d[i];
    end
    return {(^d) ^ (^h), h};
  endfunction
endpackage

// File: rtl/eccg_inject_ctrl.sv
module eccg_inject_ctrl
  import eccg_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int REG_W = ADDR_W + CHK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspAddr,
  output eccgStrobe_t       strobe
);
  logic              injEn;
  logic [ADDR_W-1:0] injAddr;
  logic [CHK_W-1:0]  injVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      injEn   <= 1'b0;
      injAddr <= '0;
      injVal  <= '0;
    end else if (regWrEn) begin
      if (regWrSel) begin
        injEn <= regWrData[0];
      end else begin
        injVal  <= regWrData[CHK_W-1:0];
        injAddr <= regWrData[REG_W-1:CHK_W];
      end
    end
  end

  always_comb begin
    strobe.sample = memRspValid;
    strobe.useInj = injEn && (memRspAddr == injAddr);
    strobe.injChk = injVal;
  end
endmodule

// File: rtl/eccg_datapath.sv
module eccg_datapath
  import eccg_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  eccgStrobe_t       strobe,
  input  logic [ADDR_W-1:0] memRspAddr,
  input  logic [DATA_W-1:0] memRspData,
  input  logic [CHK_W-1:0]  memRspChk,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              corrFault,
  output logic              uncorrFault,
  output logic [ADDR_W-1:0] faultAddr
);
  logic [CHK_W-1:0]  effChk;
  logic [CHK_W-1:0]  recalc;
  logic [HAM_W-1:0]  synH;
  logic              parOdd;
  logic              isClean;
  logic              isCorr;
  logic              isUncorr;
  logic [DATA_W-1:0] flipMask;
  logic [DATA_W-1:0] fixedData;

  always_comb begin
    effChk   = strobe.useInj ? strobe.injChk : memRspChk;
    recalc   = calcChk(memRspData);
    synH     = recalc[HAM_W-1:0] ^ effChk[HAM_W-1:0];
    parOdd   = ^{memRspData, effChk};
    isClean  = (synH == '0) && !parOdd;
    isCorr   = parOdd && (synH <= HAM_W'(CODE_LEN));
    isUncorr = !isClean && !isCorr;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam int POS = dataPos(i);
    assign flipMask[i] = isCorr && (synH == HAM_W'(POS));
  end

  assign fixedData = memRspData ^ flipMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspData     <= '0;
      rspErr      <= 1'b0;
      corrFault   <= 1'b0;
      uncorrFault <= 1'b0;
      faultAddr   <= '0;
    end else begin
      rspValid    <= strobe.sample;
      rspErr      <= strobe.sample && isUncorr;
      corrFault   <= strobe.sample && isCorr;
      uncorrFault <= strobe.sample && isUncorr;
      if (strobe.sample) begin
        rspData   <= isUncorr ? memRspData : fixedData;
        faultAddr <= memRspAddr;
      end
    end
  end
endmodule

// File: rtl/secded_read_guard.sv
module secded_read_guard
  import eccg_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  memReqValid,
  output logic [ADDR_W-1:0]     memReqAddr,
  input  logic                  memRspValid,
  input  logic [ADDR_W-1:0]     memRspAddr,
  input  logic [63:0]           memRspData,
  input  logic [7:0]            memRspChk,
  input  logic                  regWrEn,
  input  logic                  regWrSel,
  input  logic [ADDR_W+7:0]     regWrData,
  output logic                  rspValid,
  output logic [63:0]           rspData,
  output logic                  rspErr,
  output logic                  corrFault,
  output logic                  uncorrFault,
  output logic [ADDR_W-1:0]     faultAddr
);
  eccgStrobe_t strobe;

  assign memReqValid = reqValid;
  assign memReqAddr  = reqAddr;

  eccg_inject_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .memRspValid(memRspValid), .memRspAddr(memRspAddr),
    .strobe(strobe)
  );

  eccg_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memRspAddr(memRspAddr), .memRspData(memRspData), .memRspChk(memRspChk),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .corrFault(corrFault), .uncorrFault(uncorrFault), .faultAddr(faultAddr)
  );
endmodule

// File: rtl/eccg_checker.sv
module eccg_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRspValid,
  input logic [ADDR_W-1:0] memRspAddr,
  input logic              rspValid,
  input logic              rspErr,
  input logic              corrFault,
  input logic              uncorrFault,
  input logic [ADDR_W-1:0] faultAddr
);
  a_r2_one_cycle_latency: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |=> rspValid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(memRspValid));
  a_r5_err_needs_uncorr: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (uncorrFault && rspValid));
  a_r12_faults_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(corrFault && uncorrFault));
  a_r12_fault_with_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (corrFault || uncorrFault) |-> rspValid);
  a_r12_fault_addr: assert property (@(posedge clk) disable iff (!rstN)
    (corrFault || uncorrFault) |-> (faultAddr == $past(memRspAddr)));
endmodule

bind secded_read_guard eccg_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rstN(rstN), .memRspValid(memRspValid), .memRspAddr(memRspAddr),
  .rspValid(rspValid), .rspErr(rspErr), .corrFault(corrFault),
  .uncorrFault(uncorrFault), .faultAddr(faultAddr)
);

// File: tb/test_secded_read_guard.sv
`timescale 1ns/1ps
module test_secded_read_guard;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          memReqValid;
  logic [AW-1:0] memReqAddr;
  logic          memRspValid = 1'b0;
  logic [AW-1:0] memRspAddr = '0;
  logic [63:0]   memRspData = '0;
  logic [7:0]    memRspChk = '0;
  logic          regWrEn = 1'b0;
  logic          regWrSel = 1'b0;
  logic [AW+7:0] regWrData = '0;
  logic          rspValid;
  logic [63:0]   rspData;
  logic          rspErr, corrFault, uncorrFault;
  logic [AW-1:0] faultAddr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  secded_read_guard #(.ADDR_W(AW)) i_secded_read_guard (.*);

  // independent encoder from the R2 layout
  function automatic logic [7:0] benchChk(input logic [63:0] d);
    logic [6:0] syn;
    int idx;
    syn = '0;
    idx = 0;
    for (int pos = 1; pos <= 71; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[idx]) syn = syn ^ 7'(pos);
        idx++;
      end
    end
    return {(^d) ^ (^syn), syn};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sampleRsp(input string req, input logic [AW-1:0] a, input logic [63:0] expData,
                           input bit expErr, input bit expCorr, input bit expUncorr);
    check(rspValid === 1'b1, req, 64'(rspValid), 64'd1);
    check(rspData === expData, req, rspData, expData);
    check(rspErr === expErr, req, 64'(rspErr), 64'(expErr));
    check(corrFault === expCorr, req, 64'(corrFault), 64'(expCorr));
    check(uncorrFault === expUncorr, req, 64'(uncorrFault), 64'(expUncorr));
    if (expCorr || expUncorr) check(faultAddr === a, req, 64'(faultAddr), 64'(a));
  endtask

  task automatic doRead(input string req, input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] c,
                        input logic [63:0] expData, input bit expErr, input bit expCorr, input bit expUncorr);
    @(negedge clk);
    memRspValid = 1'b1; memRspAddr = a; memRspData = d; memRspChk = c;
    @(negedge clk);
    memRspValid = 1'b0;
    sampleRsp(req, a, expData, expErr, expCorr, expUncorr);
    @(negedge clk);
    // R12: pulses last one cycle
    check(!corrFault && !uncorrFault && !rspValid, "R12", {61'd0, rspValid, corrFault, uncorrFault}, 64'd0);
  endtask

  task automatic regWrite(input bit sel, input logic [AW+7:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic t_reset();
    check(!rspValid && !rspErr && !corrFault && !uncorrFault, "R1",
          {60'd0, rspValid, rspErr, corrFault, uncorrFault}, 64'd0);
    reqValid = 1'b1; reqAddr = 20'h0ABCD;
    #1;
    check(memReqValid && memReqAddr == 20'h0ABCD, "R2", 64'(memReqAddr), 64'h0ABCD);
    reqValid = 1'b0;
    // injection disabled after reset: address 0 with correct stored value is clean
    doRead("R1", '0, 64'h5A5A_0F0F_1234_8765, benchChk(64'h5A5A_0F0F_1234_8765),
           64'h5A5A_0F0F_1234_8765, 0, 0, 0);
  endtask

  task automatic t_clean();
    logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'hAAAA_5555_AAAA_5555};
    foreach (pats[i]) doRead("R2", AW'(i + 16), pats[i], benchChk(pats[i]), pats[i], 0, 0, 0);
  endtask

  task automatic t_single_data();
    logic [63:0] d = 64'hDEAD_BEEF_CAFE_F00D;
    int bits [3] = '{0, 37, 63};
    foreach (bits[i]) doRead("R3", AW'(100 + i), d ^ (64'd1 << bits[i]), benchChk(d), d, 0, 1, 0);
  endtask

  task automatic t_single_chk();
    logic [63:0] d = 64'h1357_9BDF_0246_8ACE;
    int bits [3] = '{0, 6, 7};
    foreach (bits[i]) doRead("R4", AW'(200 + i), d, benchChk(d) ^ (8'd1 << bits[i]), d, 0, 1, 0);
  endtask

  task automatic t_double();
    logic [63:0] d = 64'h0F1E_2D3C_4B5A_6978;
    logic [63:0] bd;
    bd = d ^ (64'd1 << 3) ^ (64'd1 << 40);
    doRead("R5", 20'h00301, bd, benchChk(d), bd, 1, 0, 1);
    bd = d ^ (64'd1 << 12);
    doRead("R5", 20'h00302, bd, benchChk(d) ^ 8'h04, bd, 1, 0, 1);
  endtask

  task automatic t_inject();
    logic [AW-1:0] tgt = 20'h01234;
    logic [63:0] d = 64'h8765_4321_FEDC_BA98;
    logic [7:0] good;
    good = benchChk(d);
    regWrite(0, {tgt, good});
    regWrite(1, 28'd1);
    // R6/R7: correct injected value overrides a wrong stored value
    doRead("R7", tgt, d, ~good, d, 0, 0, 0);
    // R10: still in effect on a later read
    doRead("R10", tgt, d, ~good, d, 0, 0, 0);
    // R9: other address uses stored value
    doRead("R9", 20'h01235, d, good, d, 0, 0, 0);
    doRead("R9", 20'h01235, d, good ^ 8'h10, d, 0, 1, 0);
    regWrite(0, {tgt, good ^ 8'h20});
    doRead("R8", tgt, d, good, d, 0, 1, 0);
    regWrite(0, {tgt, good ^ 8'h81});
    doRead("R8", tgt, d, good, d, 1, 0, 1);
  endtask

  task automatic t_same_cycle();
    logic [AW-1:0] tgt = 20'h01234;
    logic [63:0] d = 64'h8765_4321_FEDC_BA98;
    // injection currently enabled with two-bit-wrong value (from t_inject)
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 1'b1; regWrData = '0;
    memRspValid = 1'b1; memRspAddr = tgt; memRspData = d; memRspChk = benchChk(d);
    @(negedge clk);
    regWrEn = 1'b0; memRspValid = 1'b0;
    sampleRsp("R11", tgt, d, 1, 0, 1);
    // R10: cleared enable means stored value is used
    doRead("R10", tgt, d, benchChk(d), d, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single_data();
    t_single_chk();
    t_double();
    t_inject();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule